// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Three-State Result Port

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. A host asks for a conversion by driving the read/convert line low while the chip is selected and byte mode is off. The block then drives an active-low busy flag and walks a trial word from the most significant bit down to the least significant bit. For each bit it sets that bit, checks a one-bit comparator answer, and then keeps or clears it. When the last bit is decided, the block latches the word and releases busy.

The latched word appears on a 12-pin data port. Each pin has its own output enable, which models three-state drivers in synthesizable form. In word mode all twelve bits appear in order. In byte mode an 8-bit host can fetch the top four bits on the low pins. All sampling is synchronous to one internal clock. One bit trial takes one clock, so a conversion lasts exactly 12 cycles.

Top module: `sar_ctrl_bus`

## Requirements
- R1: At a clock edge where `rc` was high on the previous edge and is now low, `cs_n` is low, `hbe` is low and `busy` is high, a conversion starts, and `busy` reads low after that edge.
- R2: A falling `rc` with `cs_n` high or `hbe` high does not start a conversion. Holding `rc` low with no new fall does not start one either. `busy` stays high and the latched result is unchanged.
- R3: Once started, `busy` stays low for exactly 12 clock cycles and then returns high.
- R4: After the start edge, `trial` first equals 0x800. Each following cycle decides the current bit from `cmp` (1 keeps the bit, 0 clears it) and sets the next lower bit. The latched result is the word formed by the 12 decisions, MSB first. With `cmp = (trial <= code)` the result equals `code`, which is offset-binary coded (0x000 is negative full scale and 0x800 is zero).
- R5: A falling `rc` while `busy` is low is ignored. It neither lengthens the conversion nor changes its result.
- R6: The latched result changes only on the cycle `busy` rises. Reads during a conversion return the previous result.
- R7: With `cs_n` high, all twelve bits of `doe` are 0. With `cs_n` low, all twelve are 1.
- R8: With `hbe` low, `dout[11:0]` equals the latched result, with bit 11 as the MSB.
- R9: With `hbe` high, `dout[3:0]` and `dout[11:8]` both carry result bits 11..8, and `dout[7:4]` is 0.
- R10: After reset, `busy` is high, `trial` is 0 and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rc | input | 1 | Read/convert line; a qualified fall starts a conversion |
| hbe | input | 1 | Byte mode select for the data port |
| cmp | input | 1 | Comparator answer: 1 when the input is at or above the trial level |
| busy | output | 1 | Low while a conversion runs |
| trial | output | 12 | Trial word driven to the DAC |
| dout | output | 12 | Data port value |
| doe | output | 12 | Per-pin output enable of the data port |

## Verification
The hardest situation to reach is a second falling `rc` in the middle of a conversion. The host protocol would normally never produce one. The bench forces this case by toggling `rc` high and then low after several bit trials, and then checks that the busy time and the final code are both unchanged. It also reads the port while busy is low to catch any early update of the latch. Rejected starts are made by dropping `rc` with select or byte mode in the wrong state. Holding `rc` low while select returns is covered as well, and the bench then confirms that no conversion begins.

// File: rtl/sar_ctrl_bus.sv
module sar_ctrl_bus #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rc,
  input  logic         hbe,
  input  logic         cmp,
  output logic         busy,
  output logic [W-1:0] trial,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);
  localparam int IW  = $clog2(W);
  localparam int NIB = W - 8;

  logic          rc_q;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_m1;
  logic [W-1:0]  sar;
  logic [W-1:0]  result;
  logic          start;

  assign start  = busy & rc_q & ~rc & ~cs_n & ~hbe;
  assign idx_m1 = idx - 1'b1;
  assign trial  = sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      rc_q   <= 1'b1;
      sar    <= '0;
      idx    <= '0;
      result <= '0;
    end else begin
      rc_q <= rc;
      if (busy) begin
        if (start) begin
          busy <= 1'b0;
          sar  <= {1'b1, {(W-1){1'b0}}};
          idx  <= IW'(W-1);
        end
      end else if (idx == '0) begin
        result <= {sar[W-1:1], cmp};
        sar    <= '0;
        busy   <= 1'b1;
      end else begin
        sar[idx]    <= cmp;
        sar[idx_m1] <= 1'b1;
        idx         <= idx_m1;
      end
    end
  end

  assign doe  = {W{~cs_n}};
  assign dout = hbe ? {result[W-1:8], {(8-NIB){1'b0}}, result[W-1:8]} : result;

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rc_q && !rc && !cs_n && !hbe)); // R1
  AST_END_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(idx) == '0); // R3
  AST_TRIAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sar[idx] && ((sar & ((W'(1) << idx) - W'(1))) == '0))); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy) |-> $stable(result)); // R6
  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> doe == '0); // R7
  AST_BYTE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    hbe |-> (dout[7:4] == '0 && dout[3:0] == dout[11:8])); // R9
endmodule

// File: tb/tb_sar_ctrl_bus.sv
module tb_sar_ctrl_bus;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rc = 1'b1, hbe = 1'b0, cmp;
  logic busy;
  logic [11:0] trial, dout, doe;
  logic [11:0] code = '0;
  logic [11:0] last = '0;
  int total = 0, fails = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  sar_ctrl_bus dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .hbe(hbe),
                    .cmp(cmp), .busy(busy), .trial(trial), .dout(dout), .doe(doe));

  assign cmp = (trial <= code);

  function automatic logic [11:0] exp_port(input logic [11:0] r, input logic h);
    return h ? {r[11:8], 4'b0000, r[11:8]} : r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_word(input string req);
    cs_n = 1'b0; hbe = 1'b0; #1;
    chk(req, dout, last);
  endtask

  task automatic convert(input logic [11:0] c, input bit glitch);
    int n = 0;
    code = c;
    @(negedge clk); rc = 1'b1; cs_n = 1'b0; hbe = 1'b0;
    @(negedge clk); rc = 1'b0;
    @(negedge clk);
    chk("R1 busy after start", busy, 0);
    chk("R4 first trial", trial, 12'h800);
    while (!busy && n < 40) begin
      n++;
      if (n == 3) chk("R6 read during busy", dout, last);
      if (glitch && n == 4) rc = 1'b1;
      if (glitch && n == 5) rc = 1'b0;
      @(negedge clk);
    end
    chk(glitch ? "R5 busy length with glitch" : "R3 busy length", n, 12);
    last = c;
    chk(glitch ? "R5 result with glitch" : "R4 result", dout, c);
    rc = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R10 busy reset", busy, 1);
    chk("R10 trial reset", trial, 0);
    cs_n = 1'b0; #1;
    chk("R10 result reset", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    convert(12'h000, 0);
    convert(12'hFFF, 0);
    convert(12'h800, 0);
    convert(12'h7FF, 0);
    convert(12'hA5C, 1);

    @(negedge clk); cs_n = 1'b1; rc = 1'b1;
    @(negedge clk); rc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no start when deselected", busy, 1);
    cs_n = 1'b0; repeat (3) @(negedge clk);
    chk("R2 rc held low no start", busy, 1);
    read_word("R2 result kept after deselect");
    rc = 1'b1; hbe = 1'b1;
    @(negedge clk); rc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no start in byte mode", busy, 1);
    read_word("R2 result kept after byte mode");
    rc = 1'b1;

    for (int i = 0; i < 40; i++) begin
      convert(12'($urandom), ($urandom % 4) == 0);
      cs_n = 1'($urandom); hbe = 1'($urandom); #1;
      chk("R7 output enable", doe, cs_n ? 12'h000 : 12'hFFF);
      chk(hbe ? "R9 byte mapping" : "R8 word mapping", dout, exp_port(last, hbe));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule